// File: doc/BRIEF.md
# Two-Port GPIO Interrupt Controller

This block watches sixteen general-purpose pins, grouped as two ports of eight lines, and turns their activity into per-line pending flags and one shared interrupt line. Every line is configured on its own. It can be switched off, made sensitive to a level or to an edge, and made to respond to the high/rising or the low/falling sense. A line that is driven as an output never raises a request.

Pins enter through a multi-flop synchronizer. Level requests follow the synchronized pin for as long as the line stays armed. An edge request latches into a sticky flag that software clears by writing a one to the acknowledge register. Software rewrites the kind and polarity registers only after it has cleared the enable register. For that reason a disarmed line discards its sticky flag, and an edge seen while the line was disarmed never surfaces later. The pending flags of both ports are ORed into a single interrupt output.

Configuration goes through a simple write strobe. Reads are combinational from a separate read address.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every configuration register reads 0, every status register reads 0 and `irq_o` is low.
- R2: Address bit 3 selects the port (0 = port A, 1 = port B). Bits 2:0 select the register: 0 enable, 1 kind (0 level, 1 edge), 2 polarity (0 low/falling, 1 high/rising), 3 direction (1 output, 0 input), 4 status (read only), 5 acknowledge (write only, reads 0). The four configuration registers read back what was written.
- R3: Bit i of each port register belongs to line i of that port. `pin_i[i]` feeds port A line i and `pin_i[8+i]` feeds port B line i.
- R4: An armed level line reads pending while its synchronized pin equals its polarity bit, and stops reading pending as soon as the pin leaves that value. It is not latched. The flag appears in the second cycle after the pin changes.
- R5: An armed edge line latches a pending flag on a transition in its polarity direction. The flag holds until it is acknowledged and appears in the third cycle after the pin changes.
- R6: A write to acknowledge clears the sticky flags at its 1 bits and leaves the flags at its 0 bits alone. An edge that is detected in the same cycle as the acknowledge keeps its flag set.
- R7: A line whose enable bit is 0 or whose direction bit is 1 shows no status and never drives `irq_o`. Disarming a line discards its sticky flag.
- R8: A transition that occurred while a line was disarmed does not appear after the line is armed.
- R9: `irq_o` is high exactly when any status bit of either port is set.
- R10: Writes to the status register and to the reserved registers 6 and 7 change nothing. The reserved registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 16 | Asynchronous pin levels, port A in the low byte |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write address {port, register} |
| wr_data_i | input | 8 | Write data, one bit per line |
| rd_addr_i | input | 4 | Read address {port, register} |
| rd_data_o | output | 8 | Combinational read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that the pins are held stable across a clock edge that the bench drives, since they are applied at the falling edge. They also assume that at most one register write is presented per cycle. The stimulus keeps to the documented software order. Enable is cleared before kind, polarity and direction are rewritten, and the pins are left to settle before enable is restored. This means every edge that is expected comes from a single transition the bench controls, between two known pin vectors. Directed cases place a pin transition in the exact cycle of an acknowledge. They also toggle pins while a line is disarmed, to probe latency and stale history.

// File: rtl/gpio_irq_pkg.sv
// Package: shared constants and register selector type of the GPIO
// interrupt controller. Assumes a 3-bit register field per port.
package gpio_irq_pkg;

    localparam int REG_SEL_W = 3;

    typedef enum logic [REG_SEL_W-1:0] {
        REG_ENABLE = 3'd0,
        REG_KIND   = 3'd1,
        REG_POL    = 3'd2,
        REG_DIR    = 3'd3,
        REG_STATUS = 3'd4,
        REG_ACK    = 3'd5,
        REG_RSVD6  = 3'd6,
        REG_RSVD7  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic en;
        logic kind;
        logic pol;
        logic dir;
        logic ack;
    } wr_strobe_t;

endpackage

// File: rtl/gpio_irq_sync.sv
// Module: multi-flop synchronizer for a vector of asynchronous pins.
// Assumes STAGES >= 2. Every bit is treated independently; the output
// is the value seen STAGES clock edges earlier.
module gpio_irq_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage captures the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d_i;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        // Each later stage re-samples the one before it.
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[k] <= '0;
            else        stage_q[k] <= stage_q[k-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_port.sv
// Module: configuration registers and per-line request logic of one port.
// Assumes pin_sync_i is already synchronized. The port keeps one previous
// sample for edge detection. Edge requests latch until acknowledged; level
// requests follow the pin. Disarmed lines (enable 0 or output) report
// nothing and lose any latched edge.
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] pin_sync_i,
    input  wr_strobe_t       we_i,
    input  logic [LINES-1:0] wr_data_i,
    output logic [LINES-1:0] en_o,
    output logic [LINES-1:0] kind_o,
    output logic [LINES-1:0] pol_o,
    output logic [LINES-1:0] dir_o,
    output logic [LINES-1:0] status_o
);
    logic [LINES-1:0] en_q, kind_q, pol_q, dir_q;
    logic [LINES-1:0] prev_q, sticky_q;
    logic [LINES-1:0] armed, armed_edge, armed_level;
    logic [LINES-1:0] evt, ack_clr, sticky_d, level_hit;

    // Configuration registers, each loaded by its own strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            kind_q <= '0;
            pol_q  <= '0;
            dir_q  <= '0;
        end else begin
            if (we_i.en)   en_q   <= wr_data_i;
            if (we_i.kind) kind_q <= wr_data_i;
            if (we_i.pol)  pol_q  <= wr_data_i;
            if (we_i.dir)  dir_q  <= wr_data_i;
        end
    end

    // Previous synchronized sample, always tracked so history stays fresh.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pin_sync_i;
    end

    // Arming and event decode per line.
    always_comb begin
        armed       = en_q & ~dir_q;
        armed_edge  = armed & kind_q;
        armed_level = armed & ~kind_q;
        evt         = (pol_q & pin_sync_i & ~prev_q) |
                      (~pol_q & ~pin_sync_i & prev_q);
        ack_clr     = we_i.ack ? wr_data_i : '0;
        level_hit   = armed_level & ~(pin_sync_i ^ pol_q);
        sticky_d    = armed_edge & ((sticky_q & ~ack_clr) | evt);
    end

    // Sticky edge flags: set wins over acknowledge, disarm discards.
    always_ff @(posedge clk) begin
        if (!rst_n) sticky_q <= '0;
        else        sticky_q <= sticky_d;
    end

    assign status_o = (sticky_q & armed_edge) | level_hit;
    assign en_o     = en_q;
    assign kind_o   = kind_q;
    assign pol_o    = pol_q;
    assign dir_o    = dir_q;

    for (genvar i = 0; i < LINES; i++) begin : g_chk
        // R5: a detected edge on an armed edge line is latched.
        p_edge_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (armed_edge[i] && evt[i]) |=> sticky_q[i]);
        // R5/R6: a latched flag holds while armed and not acknowledged.
        p_sticky_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (armed_edge[i] && sticky_q[i] && !ack_clr[i]) |=> sticky_q[i]);
        // R7: disarming drops any latched edge.
        p_disarm_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (!armed_edge[i]) |=> !sticky_q[i]);
        // R4: a level line whose pin left the polarity stays quiet.
        p_level_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!kind_q[i] && (pin_sync_i[i] != pol_q[i])) |-> !status_o[i]);
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
// Module: top of the two-port GPIO interrupt controller. Synchronizes the
// pins, decodes writes into per-port strobes, muxes reads and ORs all
// status into one request. Assumes one write per cycle; reads are
// combinational.
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PORTS   = 2,
    parameter int LINES       = 8,
    parameter int SYNC_STAGES = 2,
    localparam int PORT_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int ADDR_W     = PORT_W + REG_SEL_W,
    localparam int NPINS      = NUM_PORTS * LINES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [LINES-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [LINES-1:0]  rd_data_o,
    output logic              irq_o
);
    logic [NPINS-1:0] pin_sync;
    logic [LINES-1:0] en_a     [NUM_PORTS];
    logic [LINES-1:0] kind_a   [NUM_PORTS];
    logic [LINES-1:0] pol_a    [NUM_PORTS];
    logic [LINES-1:0] dir_a    [NUM_PORTS];
    logic [LINES-1:0] status_a [NUM_PORTS];
    logic [NUM_PORTS-1:0] port_req;
    logic [NUM_PORTS-1:0] port_armed;

    reg_sel_e          wr_sel, rd_sel;
    logic [PORT_W-1:0] wr_port, rd_port;

    assign wr_sel  = reg_sel_e'(wr_addr_i[REG_SEL_W-1:0]);
    assign rd_sel  = reg_sel_e'(rd_addr_i[REG_SEL_W-1:0]);
    assign wr_port = wr_addr_i[ADDR_W-1:REG_SEL_W];
    assign rd_port = rd_addr_i[ADDR_W-1:REG_SEL_W];

    gpio_irq_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (pin_sync)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        wr_strobe_t we;
        logic       hit;

        // Decode this port's write strobes.
        always_comb begin
            hit     = wr_en_i && (wr_port == PORT_W'(p));
            we.en   = hit && (wr_sel == REG_ENABLE);
            we.kind = hit && (wr_sel == REG_KIND);
            we.pol  = hit && (wr_sel == REG_POL);
            we.dir  = hit && (wr_sel == REG_DIR);
            we.ack  = hit && (wr_sel == REG_ACK);
        end

        gpio_irq_port #(.LINES(LINES)) u_port (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin_sync_i (pin_sync[p*LINES +: LINES]),
            .we_i       (we),
            .wr_data_i  (wr_data_i),
            .en_o       (en_a[p]),
            .kind_o     (kind_a[p]),
            .pol_o      (pol_a[p]),
            .dir_o      (dir_a[p]),
            .status_o   (status_a[p])
        );

        assign port_req[p]   = |status_a[p];
        assign port_armed[p] = |(en_a[p] & ~dir_a[p]);
    end

    // Read multiplexer over port and register select.
    always_comb begin
        rd_data_o = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (rd_port == PORT_W'(p)) begin
                unique case (rd_sel)
                    REG_ENABLE: rd_data_o = en_a[p];
                    REG_KIND:   rd_data_o = kind_a[p];
                    REG_POL:    rd_data_o = pol_a[p];
                    REG_DIR:    rd_data_o = dir_a[p];
                    REG_STATUS: rd_data_o = status_a[p];
                    default:    rd_data_o = '0;
                endcase
            end
        end
    end

    assign irq_o = |port_req;

    // R7: with no armed line anywhere the request stays low.
    p_quiet_unarmed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (port_armed == '0) |-> !irq_o);
    // R2: acknowledge reads as zero.
    p_ack_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == REG_ACK) |-> (rd_data_o == '0));
    // R10: reserved registers read as zero.
    p_rsvd_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == REG_RSVD6 || rd_sel == REG_RSVD7) |-> (rd_data_o == '0));
endmodule

// File: tb/gpio_irq_ctrl_bench.sv
module gpio_irq_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pin_i = '0;
    logic        wr_en_i = 1'b0;
    logic [3:0]  wr_addr_i = '0;
    logic [7:0]  wr_data_i = '0;
    logic [3:0]  rd_addr_i = '0;
    logic [7:0]  rd_data_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_ctrl u_gpio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
        .rd_data_o(rd_data_o), .irq_o(irq_o)
    );

    localparam logic [2:0] A_EN = 3'd0, A_KIND = 3'd1, A_POL = 3'd2,
                           A_DIR = 3'd3, A_STAT = 3'd4, A_ACK = 3'd5;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input bit port, input logic [2:0] r, input logic [7:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = {port, r}; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input bit port, input logic [2:0] r, output logic [7:0] d);
        rd_addr_i = {port, r};
        #1;
        d = rd_data_o;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Edge events between two pin vectors for the given polarity.
    function automatic logic [7:0] edge_ev(input logic [7:0] pol, input logic [7:0] p0, input logic [7:0] p1);
        return (pol & ~p0 & p1) | (~pol & p0 & ~p1);
    endfunction

    // Expected status from the requirements (R4, R5, R7).
    function automatic logic [7:0] exp_stat(input logic [7:0] en, input logic [7:0] kind,
            input logic [7:0] pol, input logic [7:0] dir, input logic [7:0] sticky, input logic [7:0] pin);
        logic [7:0] armed;
        armed = en & ~dir;
        return (armed & kind & sticky) | (armed & ~kind & ~(pin ^ pol));
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, d2;
        logic [7:0] en [2], kind [2], pol [2], dir [2], p0 [2], p1 [2], stk [2], ackm [2];
        void'($urandom(32'h1bad5eed));

        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1: reset values
        for (int p = 0; p < 2; p++) begin
            for (int r = 0; r < 5; r++) begin
                rd(p[0], r[2:0], d);
                check("R1 reset register", {8'h0, d}, 16'h0);
            end
        end
        check("R1 reset irq", {15'h0, irq_o}, 16'h0);

        // R2/R3: readback of configuration registers, per port
        wr(0, A_EN, 8'hA5); wr(0, A_KIND, 8'h3C); wr(0, A_POL, 8'h0F); wr(0, A_DIR, 8'hC3);
        wr(1, A_EN, 8'h5A); wr(1, A_KIND, 8'h96); wr(1, A_POL, 8'hF0); wr(1, A_DIR, 8'h81);
        rd(0, A_EN, d);   check("R2 enable A readback", {8'h0, d}, 16'h00A5);
        rd(0, A_KIND, d); check("R2 kind A readback", {8'h0, d}, 16'h003C);
        rd(0, A_POL, d);  check("R2 pol A readback", {8'h0, d}, 16'h000F);
        rd(0, A_DIR, d);  check("R2 dir A readback", {8'h0, d}, 16'h00C3);
        rd(1, A_EN, d);   check("R3 enable B readback", {8'h0, d}, 16'h005A);
        rd(1, A_DIR, d);  check("R3 dir B readback", {8'h0, d}, 16'h0081);
        rd(0, A_ACK, d);  check("R2 ack reads zero", {8'h0, d}, 16'h0);

        // Clean configuration
        for (int p = 0; p < 2; p++) begin
            wr(p[0], A_EN, 8'h00); wr(p[0], A_KIND, 8'h00);
            wr(p[0], A_POL, 8'h00); wr(p[0], A_DIR, 8'h00);
        end
        pin_i = 16'h0000;
        idle(5);

        // R4 latency: port A line 1 level-high
        wr(0, A_POL, 8'h02); wr(0, A_EN, 8'h02);
        idle(2);
        check("R4 level quiet before pin", {15'h0, irq_o}, 16'h0);
        pin_i[1] = 1'b1;
        @(negedge clk);
        check("R4 level not yet at 1 cycle", {15'h0, irq_o}, 16'h0);
        @(negedge clk);
        check("R4 level pending at 2 cycles", {15'h0, irq_o}, 16'h1);
        pin_i[1] = 1'b0;
        idle(3);
        rd(0, A_STAT, d);
        check("R4 level not latched", {8'h0, d}, 16'h0);
        wr(0, A_EN, 8'h00);

        // R5 latency: port B line 0 edge-rising, pin 8
        wr(1, A_KIND, 8'h01); wr(1, A_POL, 8'h01); wr(1, A_EN, 8'h01);
        idle(2);
        pin_i[8] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R5 edge not yet at 2 cycles", {15'h0, irq_o}, 16'h0);
        @(negedge clk);
        check("R5 edge pending at 3 cycles", {15'h0, irq_o}, 16'h1);
        pin_i[8] = 1'b0;
        idle(4);
        rd(1, A_STAT, d);
        check("R5 edge flag holds after pin falls", {8'h0, d}, 16'h0001);
        check("R9 irq from port B", {15'h0, irq_o}, 16'h1);

        // R10: writes to status and reserved registers ignored
        wr(1, A_STAT, 8'h00); wr(1, 3'd6, 8'hFF); wr(1, 3'd7, 8'hFF);
        rd(1, A_STAT, d);
        check("R10 status write ignored", {8'h0, d}, 16'h0001);
        rd(1, 3'd6, d);
        check("R10 reserved reads zero", {8'h0, d}, 16'h0);

        // R6: ack with 0 bits no effect, then simultaneous edge + ack keeps flag
        wr(1, A_ACK, 8'hFE);
        rd(1, A_STAT, d);
        check("R6 ack zero bit no effect", {8'h0, d}, 16'h0001);
        pin_i[8] = 1'b1;
        @(negedge clk);
        wr(1, A_ACK, 8'h01);
        rd(1, A_STAT, d);
        check("R6 edge coincident with ack kept", {8'h0, d}, 16'h0001);
        wr(1, A_ACK, 8'h01);
        rd(1, A_STAT, d);
        check("R6 ack clears flag", {8'h0, d}, 16'h0);
        check("R9 irq low after ack", {15'h0, irq_o}, 16'h0);

        // R7: disarm discards sticky flag
        pin_i[8] = 1'b0; idle(4);
        pin_i[8] = 1'b1; idle(4);
        wr(1, A_EN, 8'h00);
        wr(1, A_EN, 8'h01);
        rd(1, A_STAT, d);
        check("R7 disable drops sticky", {8'h0, d}, 16'h0);

        // R8: edge while disarmed does not surface
        wr(1, A_EN, 8'h00);
        pin_i[8] = 1'b0; idle(4);
        pin_i[8] = 1'b1; idle(4);
        wr(1, A_EN, 8'h01);
        idle(3);
        rd(1, A_STAT, d);
        check("R8 stale edge ignored", {8'h0, d}, 16'h0);

        // R7: output line never requests
        wr(1, A_EN, 8'h00); wr(1, A_DIR, 8'h01); wr(1, A_EN, 8'h01);
        pin_i[8] = 1'b0; idle(4);
        pin_i[8] = 1'b1; idle(4);
        rd(1, A_STAT, d);
        check("R7 output line quiet", {8'h0, d}, 16'h0);
        check("R7 output line irq low", {15'h0, irq_o}, 16'h0);

        // Random rounds
        for (int it = 0; it < 40; it++) begin
            for (int p = 0; p < 2; p++) begin
                en[p] = 8'($urandom); kind[p] = 8'($urandom);
                pol[p] = 8'($urandom); dir[p] = 8'($urandom & $urandom);
                p0[p] = 8'($urandom); p1[p] = 8'($urandom);
                ackm[p] = 8'($urandom);
                wr(p[0], A_EN, 8'h00);
                wr(p[0], A_KIND, kind[p]); wr(p[0], A_POL, pol[p]); wr(p[0], A_DIR, dir[p]);
            end
            pin_i = {p0[1], p0[0]};
            idle(5);
            wr(0, A_EN, en[0]); wr(1, A_EN, en[1]);
            idle(3);
            for (int p = 0; p < 2; p++) begin
                rd(p[0], A_STAT, d);
                check("R8 R4 status after enable", {8'h0, d},
                      {8'h0, exp_stat(en[p], kind[p], pol[p], dir[p], 8'h00, p0[p])});
            end
            pin_i = {p1[1], p1[0]};
            idle(5);
            for (int p = 0; p < 2; p++) begin
                stk[p] = edge_ev(pol[p], p0[p], p1[p]);
                rd(p[0], A_STAT, d);
                check("R5 R4 R7 status after toggle", {8'h0, d},
                      {8'h0, exp_stat(en[p], kind[p], pol[p], dir[p], stk[p], p1[p])});
            end
            check("R9 combined irq", {15'h0, irq_o},
                  {15'h0, (|exp_stat(en[0], kind[0], pol[0], dir[0], stk[0], p1[0])) |
                          (|exp_stat(en[1], kind[1], pol[1], dir[1], stk[1], p1[1]))});
            wr(0, A_ACK, ackm[0]); wr(1, A_ACK, ackm[1]);
            for (int p = 0; p < 2; p++) begin
                rd(p[0], A_STAT, d2);
                check("R6 status after ack", {8'h0, d2},
                      {8'h0, exp_stat(en[p], kind[p], pol[p], dir[p], stk[p] & ~ackm[p], p1[p])});
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule